// File: doc/BRIEF.md
# Mask-Oriented Trailing-Bit Manipulation Unit

This block is an execution unit for one bit-manipulation operation aimed at predicate-mask work. It takes a source word and an optional mask word. A flag says the mask register is absent, and in that case the mask is all ones. A 5-bit mode field and a restore flag complete the inputs. The source is first ANDed with the mask, giving a working value. From it the unit forms two patterns:

- the working value itself, or its inverse;
- one of four increment/decrement idioms.

It combines the two patterns with OR, AND or XOR, and masks the result. On request it then merges back the source bits that lie outside the mask. One datapath covers the whole family of trailing-bit idioms: isolate the lowest set bit, clear it, set the trailing zeros, and isolate or set the lowest clear bit. Each of these can be confined to a mask.

The operator code 3 is reserved. It raises an illegal-instruction flag for the trap logic outside the block, and the result is forced to zero. The block changes no status state. Operands enter through a valid/ready handshake, and the result leaves from an output register one clock after acceptance.

Top module: `maskbit_unit`

## Requirements
- R1: With `mask_absent` = 1 the effective mask is all ones and `mask_b` has no effect; with `mask_absent` = 0 the effective mask is `mask_b`. The working value is `src_a & mask`.
- R2: Mode bit `mode[0]` picks the first pattern: 1 gives the working value, 0 gives its bitwise inverse.
- R3: Mode bits `mode[2:1]` pick the second pattern from the working value: 0 gives (~x)+1, 1 gives x-1, 2 gives x+1, 3 gives ~(x+1). All sums wrap modulo 2^DATA_W with no carry output.
- R4: Mode bits `mode[4:3]` pick the operator: 0 is OR, 1 is AND, 2 is XOR. Both patterns are ANDed with the mask before they are combined.
- R5: With `restore` = 0 every result bit outside the mask is 0, because the combined value is ANDed with the mask.
- R6: With `restore` = 1 every result bit outside the mask equals the matching bit of the unmasked `src_a`, and the bits inside the mask are as in R5.
- R7: With `mode[4:3]` = 3 the output carries `out_illegal` = 1 and `out_result` = 0 whatever the restore flag is. For every other operator code `out_illegal` = 0.
- R8: An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. Its result and flag appear on the outputs after that edge, with `out_valid` = 1.
- R9: While `out_valid` = 1 and `out_ready` = 0, the outputs hold steady and `in_ready` = 0, so new input is not taken. With `out_ready` = 1, `in_ready` = 1.
- R10: A synchronous active-high `rst` clears `out_valid`; after reset `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Unit can take operands this cycle |
| src_a | input | DATA_W | Source operand |
| mask_b | input | DATA_W | Mask operand |
| mask_absent | input | 1 | 1 = no mask register, use all ones |
| mode | input | 5 | [0] first pattern, [2:1] second pattern, [4:3] operator |
| restore | input | 1 | 1 = merge source bits outside the mask |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | DATA_W | Result word |
| out_illegal | output | 1 | Reserved operator code was used |

## Verification
The bench builds the unit at its default width of 64 bits. At that width, wrap-around of x-1 on zero and of x+1 on all ones reaches the top bit. A restore case with bits set in the upper byte shows that the merge works across the full word and not just in a low slice. The idiom vectors are chosen so that each of the four second-pattern variants and each operator yields a distinct value. A mask that differs from all ones separates the R1 absent/present paths. Backpressure sequences exercise the hold and the blocked-input behaviour.

// File: rtl/maskbit_pkg.sv
package maskbit_pkg;
  localparam int MODE_W = 5;

  typedef enum logic [1:0] {
    OP_OR   = 2'd0,
    OP_AND  = 2'd1,
    OP_XOR  = 2'd2,
    OP_RSVD = 2'd3
  } mb_op_e;

  typedef enum logic [1:0] {
    P2_NEG  = 2'd0,
    P2_DEC  = 2'd1,
    P2_INC  = 2'd2,
    P2_NINC = 2'd3
  } mb_p2_e;

  typedef struct packed {
    mb_op_e op;
    mb_p2_e p2;
    logic   keep_plain;
  } mb_mode_t;
endpackage

// File: rtl/mb_mask_sel.sv
module mb_mask_sel #(
  parameter int DATA_W = 64
) (
  input  logic              absent,
  input  logic [DATA_W-1:0] mask_in,
  output logic [DATA_W-1:0] eff_mask
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign eff_mask[i] = absent | mask_in[i];
  end
endmodule

// File: rtl/mb_patterns.sv
module mb_patterns
  import maskbit_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] mask,
  input  logic              keep_plain,
  input  mb_p2_e            p2_sel,
  output logic [DATA_W-1:0] work,
  output logic [DATA_W-1:0] pat1,
  output logic [DATA_W-1:0] pat2
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  function automatic logic [DATA_W-1:0] first_pat(input logic [DATA_W-1:0] x,
                                                  input logic plain);
    return plain ? x : ~x;
  endfunction

  function automatic logic [DATA_W-1:0] second_pat(input logic [DATA_W-1:0] x,
                                                   input mb_p2_e sel);
    logic [DATA_W-1:0] r;
    case (sel)
      P2_NEG:  r = (~x) + ONE;
      P2_DEC:  r = x - ONE;
      P2_INC:  r = x + ONE;
      default: r = ~(x + ONE);
    endcase
    return r;
  endfunction

  assign work = src & mask;
  assign pat1 = first_pat(work, keep_plain) & mask;
  assign pat2 = second_pat(work, p2_sel) & mask;
endmodule

// File: rtl/mb_combine.sv
module mb_combine
  import maskbit_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] pat1,
  input  logic [DATA_W-1:0] pat2,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] src,
  input  mb_op_e            op,
  input  logic              restore,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  function automatic logic [DATA_W-1:0] apply_op(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input mb_op_e o);
    logic [DATA_W-1:0] r;
    case (o)
      OP_OR:   r = a | b;
      OP_AND:  r = a & b;
      OP_XOR:  r = a ^ b;
      default: r = '0;
    endcase
    return r;
  endfunction

  logic [DATA_W-1:0] inside_bits;
  logic [DATA_W-1:0] outside_bits;

  assign illegal      = (op == OP_RSVD);
  assign inside_bits  = apply_op(pat1, pat2, op) & mask;
  assign outside_bits = restore ? (src & ~mask) : '0;

  always_comb begin
    if (illegal) result = '0;
    else         result = inside_bits | outside_bits;
  end
endmodule

// File: rtl/mb_out_stage.sv
module mb_out_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] nxt_result,
  input  logic              nxt_illegal,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  logic in_fire;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      out_result  <= nxt_result;
      out_illegal <= nxt_illegal;
    end
  end

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_fire |=> out_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0));
endmodule

// File: rtl/maskbit_unit.sv
module maskbit_unit
  import maskbit_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] mask_b,
  input  logic              mask_absent,
  input  logic [MODE_W-1:0] mode,
  input  logic              restore,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  mb_mode_t          mode_f;
  logic [DATA_W-1:0] eff_mask;
  logic [DATA_W-1:0] work_val;
  logic [DATA_W-1:0] pat1_m;
  logic [DATA_W-1:0] pat2_m;
  logic [DATA_W-1:0] comb_result;
  logic              comb_illegal;
  logic              accept_evt;

  assign mode_f     = mb_mode_t'(mode);
  assign accept_evt = in_valid && in_ready;

  mb_mask_sel #(.DATA_W(DATA_W)) u_mask (
    .absent   (mask_absent),
    .mask_in  (mask_b),
    .eff_mask (eff_mask)
  );

  mb_patterns #(.DATA_W(DATA_W)) u_pat (
    .src        (src_a),
    .mask       (eff_mask),
    .keep_plain (mode_f.keep_plain),
    .p2_sel     (mode_f.p2),
    .work       (work_val),
    .pat1       (pat1_m),
    .pat2       (pat2_m)
  );

  mb_combine #(.DATA_W(DATA_W)) u_comb (
    .pat1    (pat1_m),
    .pat2    (pat2_m),
    .mask    (eff_mask),
    .src     (src_a),
    .op      (mode_f.op),
    .restore (restore),
    .result  (comb_result),
    .illegal (comb_illegal)
  );

  mb_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .nxt_result  (comb_result),
    .nxt_illegal (comb_illegal),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
  );

  // R1
  work_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |-> ((work_val & ~eff_mask) == '0));

  // R4
  pats_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |-> (((pat1_m | pat2_m) & ~eff_mask) == '0));

  // R5
  masked_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_evt && !restore) |-> ((comb_result & ~eff_mask) == '0));

  // R6
  restore_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_evt && restore && !comb_illegal) |-> (((comb_result ^ src_a) & ~eff_mask) == '0));
endmodule

// File: tb/maskbit_unit_test.sv
module maskbit_unit_test;
  localparam int W = 64;

  typedef struct packed {
    logic [W-1:0] src;
    logic [W-1:0] mb;
    logic         absent;
    logic [4:0]   mode;
    logic         rst_flag;
    logic [W-1:0] exp;
    logic         ill;
  } vec_t;

  localparam int NV = 14;
  // fields: src, mask_b, absent, mode, restore, expected, illegal
  localparam vec_t VECS [NV] = '{
    '{64'h58, 64'h0, 1'b1, 5'h09, 1'b0, 64'h08, 1'b0},                  // R2 R3 R4 x&-x
    '{64'h58, 64'h0, 1'b1, 5'h0B, 1'b0, 64'h50, 1'b0},                  // R3 R4 x&(x-1)
    '{64'h58, 64'h0, 1'b1, 5'h03, 1'b0, 64'h5F, 1'b0},                  // R4 x|(x-1)
    '{64'h58, 64'h0, 1'b1, 5'h13, 1'b0, 64'h0F, 1'b0},                  // R4 x^(x-1)
    '{64'h58, 64'h0, 1'b1, 5'h0C, 1'b0, 64'h01, 1'b0},                  // R2 ~x&(x+1)
    '{64'h58, 64'h0, 1'b1, 5'h05, 1'b0, 64'h59, 1'b0},                  // R3 x|(x+1)
    '{64'h58, 64'h0, 1'b1, 5'h16, 1'b0, 64'h01, 1'b0},                  // R3 ~x ^ ~(x+1)
    '{64'hFF00_0000_0000_00F0, 64'hFF, 1'b0, 5'h09, 1'b1,
      64'hFF00_0000_0000_0010, 1'b0},                                    // R6 restore
    '{64'hFF00_0000_0000_00F0, 64'hFF, 1'b0, 5'h09, 1'b0, 64'h10, 1'b0}, // R5 no restore
    '{64'h58, 64'h0, 1'b1, 5'h19, 1'b1, 64'h0, 1'b1},                   // R7 reserved
    '{64'h0, 64'h0, 1'b1, 5'h03, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},  // R3 wrap 0-1
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 5'h0D, 1'b0, 64'h0, 1'b0},  // R3 wrap ones+1
    '{64'h58, 64'h0F, 1'b0, 5'h03, 1'b0, 64'h0F, 1'b0},                 // R1 mask used
    '{64'h58, 64'hF0, 1'b0, 5'h02, 1'b0, 64'hE0, 1'b0}                  // R2 R4 inverse masked
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] src_a;
  logic [W-1:0] mask_b;
  logic         mask_absent;
  logic [4:0]   mode;
  logic         restore;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_result;
  logic         out_illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  maskbit_unit #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .mask_b(mask_b), .mask_absent(mask_absent), .mode(mode),
    .restore(restore), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] s, input logic [W-1:0] m, input logic a,
                       input logic [4:0] md, input logic r);
    src_a = s; mask_b = m; mask_absent = a; mode = md; restore = r;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    drive('0, '0, 1'b1, 5'h0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 out_valid after reset", W'(out_valid), W'(0));
    check("R10 in_ready after reset", W'(in_ready), W'(1));

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].src, VECS[i].mb, VECS[i].absent, VECS[i].mode, VECS[i].rst_flag);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R8 vec%0d valid", i), W'(out_valid), W'(1));
      check($sformatf("R1-R7 vec%0d result", i), out_result, VECS[i].exp);
      check($sformatf("R7 vec%0d illegal", i), W'(out_illegal), W'(VECS[i].ill));
    end

    // R1 same inputs as last mask case but mask absent: mask_b ignored
    drive(64'h58, 64'h0F, 1'b1, 5'h03, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 absent ignores mask_b", out_result, 64'h5F);

    // R7 reserved with restore clear also zero
    drive(64'hFFFF_0000_0000_1234, 64'hFF, 1'b0, 5'h1F, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 reserved result", out_result, 64'h0);
    check("R7 reserved flag", W'(out_illegal), W'(1));

    // R9 backpressure
    @(negedge clk);
    check("R8 valid drops when drained", W'(out_valid), W'(0));
    out_ready = 1'b0;
    drive(64'h58, 64'h0, 1'b1, 5'h09, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    check("R9 first held result", out_result, 64'h08);
    check("R9 in_ready low while stalled", W'(in_ready), W'(0));
    drive(64'h58, 64'h0, 1'b1, 5'h05, 1'b0);
    repeat (2) @(negedge clk);
    check("R9 result held under stall", out_result, 64'h08);
    check("R9 valid held under stall", W'(out_valid), W'(1));
    out_ready = 1'b1;
    #1;
    check("R9 in_ready with out_ready", W'(in_ready), W'(1));
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next result after release", out_result, 64'h59);

    // R10 reset while holding
    out_ready = 1'b0;
    drive(64'h58, 64'h0, 1'b1, 5'h0B, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 stalled valid", W'(out_valid), W'(1));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset clears valid", W'(out_valid), W'(0));
    out_ready = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule